// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns one indexed-addressing postbyte, together with up to two extension bytes, into a 16-bit operand address for a small accumulator-style processor. It picks a base register from four candidates: X, Y, the stack pointer or the program counter. It then adds one of three things to that base: a constant taken from the postbyte or the extension bytes, an accumulator value, or a signed auto-step. For auto-step forms it also returns the stepped base value and a one-cycle write-back strobe, so the register file can keep the modified register.

Two forms are indirect: base plus a 16-bit constant, and base plus the double accumulator. For these, the sum is a pointer. The block reads the word at that pointer through a byte-wide read port with a fixed latency of one cycle. The high byte is at the lower address. The word that comes back is the final address. Every result is marked by a single-cycle `done` pulse.

The caller pulses `start` with all inputs valid in the same cycle. While a pointer fetch is in flight, new starts are dropped.

Top module: `idx_ea_gen`

## Requirements
- R1: The base register is chosen by a two-bit field, with 00=X, 01=Y, 10=SP and 11=PC. The field sits in postbyte bits 7:6 for the short-offset and auto-step forms, and in bits 4:3 for forms whose bits 7:5 are 111.
- R2: A postbyte with bit 5 clear adds bits 4:0, read as a signed value from -16 to +15, to the base. `done` and `ea` are valid in the cycle after the start cycle.
- R3: A postbyte of the form 111rr00s adds a 9-bit signed offset. Bit 0 of the postbyte is the sign, and `ext_hi` supplies the low eight bits.
- R4: A postbyte of the form 111rr010 adds the 16-bit offset {`ext_hi`,`ext_lo`}.
- R5: A postbyte with bit 5 set and bits 7:5 not equal to 111 is an auto-step form. Bits 3:0 encode +1..+8 as 0000..0111 and -1..-8 as 1111..1000. Bit 4 set means post-step: `ea` is the unmodified base. Bit 4 clear means pre-step: `ea` is the stepped base. In the `done` cycle, `wb_en` is 1, `wb_sel` carries the register field and `wb_val` carries the stepped base.
- R6: Only auto-step forms raise `wb_en`. `wb_sel` is never 11 (PC), because every postbyte that would name PC for stepping falls in the 111 group.
- R7: A postbyte of the form 111rr1aa adds an accumulator offset. aa=00 adds A zero-extended, aa=01 adds B zero-extended, and aa=10 adds D={A,B}.
- R8: Postbytes 111rr011 (16-bit constant) and 111rr111 (D offset) are indirect. The sum is a pointer P. The block reads P and then P+1, with `mem_rdata` valid in the cycle after each `mem_rd`. `ea` = {byte at P, byte at P+1}, and `done` comes four cycles after the start cycle.
- R9: All sums wrap modulo 2^16, and this includes the address P+1 of the second pointer byte.
- R10: A `start` that arrives while a pointer fetch is in progress is ignored. `done` and `wb_en` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one address computation |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext_hi | input | 8 | First extension byte |
| ext_lo | input | 8 | Second extension byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| done | output | 1 | Final address valid this cycle |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_val | output | 16 | Stepped base value |

## Verification
Two things can fall in the same cycle. First, the write-back of a stepped base and the delivery of the address always share the `done` cycle. The bench therefore checks `ea`, `wb_en`, `wb_sel` and `wb_val` together in that single sampled cycle, for both pre-step and post-step with positive and negative steps. Second, a new request can arrive while a pointer fetch is still running. The bench issues an auto-step start one cycle into an indirect fetch. It then judges that exactly one `done` appears, at the indirect latency, carrying the pointer word, and that `wb_en` never rises.

// File: rtl/idx_ea_pkg.sv
// Shared types for the indexed effective address generator.
// Assumes a 16-bit address space built from 8-bit bytes.
package idx_ea_pkg;

    // Class of address computation chosen by a postbyte
    typedef enum logic [1:0] {
        EA_OFFSET   = 2'd0,
        EA_STEP     = 2'd1,
        EA_INDIRECT = 2'd2
    } ea_kind_t;

    // Pointer fetch sequencer states
    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_HI   = 2'd1,
        PF_LO   = 2'd2,
        PF_FIN  = 2'd3
    } pf_state_t;

endpackage

// File: rtl/idx_pb_decode.sv
// Postbyte decoder: classifies the postbyte, extracts the register field,
// builds the constant or accumulator offset and the signed auto-step amount.
// Purely combinational; assumes AW is twice BW.
module idx_pb_decode
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [BW-1:0] postbyte,
    input  logic [BW-1:0] ext_hi,
    input  logic [BW-1:0] ext_lo,
    input  logic [BW-1:0] acc_a,
    input  logic [BW-1:0] acc_b,
    output ea_kind_t      kind,
    output logic [1:0]    rsel,
    output logic          pre_step,
    output logic [AW-1:0] offset,
    output logic [AW-1:0] step
);

    localparam int SHORT_W = 5;
    localparam int STEP_W  = 4;

    // Decode form, register field and offset from the postbyte
    always_comb begin
        kind     = EA_OFFSET;
        rsel     = postbyte[7:6];
        pre_step = 1'b0;
        offset   = '0;
        if (!postbyte[5]) begin
            offset = {{(AW-SHORT_W){postbyte[4]}}, postbyte[SHORT_W-1:0]};
        end else if (postbyte[7:5] != 3'b111) begin
            kind     = EA_STEP;
            pre_step = !postbyte[4];
        end else begin
            rsel = postbyte[4:3];
            if (!postbyte[2]) begin
                if (!postbyte[1]) begin
                    offset = {{(AW-BW){postbyte[0]}}, ext_hi};
                end else begin
                    offset = {ext_hi, ext_lo};
                    if (postbyte[0]) kind = EA_INDIRECT;
                end
            end else begin
                case (postbyte[1:0])
                    2'b00:   offset = {{(AW-BW){1'b0}}, acc_a};
                    2'b01:   offset = {{(AW-BW){1'b0}}, acc_b};
                    default: offset = {acc_a, acc_b};
                endcase
                if (postbyte[1:0] == 2'b11) kind = EA_INDIRECT;
            end
        end
    end

    // Signed step amount: 0..7 map to +1..+8, 8..15 are -8..-1
    always_comb begin
        if (postbyte[STEP_W-1])
            step = {{(AW-STEP_W){1'b1}}, postbyte[STEP_W-1:0]};
        else
            step = {{(AW-STEP_W){1'b0}}, postbyte[STEP_W-1:0]} + AW'(1);
    end

endmodule

// File: rtl/idx_addr_calc.sv
// Address adder: selects the base register and forms the operand sum and
// the stepped base value. All sums wrap at the address width.
module idx_addr_calc
    import idx_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  ea_kind_t      kind,
    input  logic [1:0]    rsel,
    input  logic          pre_step,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_pc,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] stepped
);

    logic [AW-1:0] base;
    logic [AW-1:0] addend;

    // Base register multiplexer (00 X, 01 Y, 10 SP, 11 PC)
    always_comb begin
        case (rsel)
            2'b00:   base = reg_x;
            2'b01:   base = reg_y;
            2'b10:   base = reg_sp;
            default: base = reg_pc;
        endcase
    end

    // Addend: step only for pre-step, nothing for post-step, else offset
    always_comb begin
        if (kind == EA_STEP)
            addend = pre_step ? step : '0;
        else
            addend = offset;
    end

    assign sum     = base + addend;
    assign stepped = base + step;

endmodule

// File: rtl/idx_ptr_fetch.sv
// Pointer word reader: on launch, reads two bytes (high byte first, at the
// pointer; low byte at pointer+1) from a port whose data returns one cycle
// after each request. In PF_FIN the assembled word is presented on ptr_word.
module idx_ptr_fetch
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] ptr,
    input  logic [BW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          fin,
    output logic [AW-1:0] ptr_word
);

    pf_state_t     state;
    logic [AW-1:0] ptr_q;
    logic [BW-1:0] hi_q;

    // Sequencer and captured pointer/high byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PF_IDLE;
            ptr_q <= '0;
            hi_q  <= '0;
        end else begin
            case (state)
                PF_IDLE: if (launch) begin
                    state <= PF_HI;
                    ptr_q <= ptr;
                end
                PF_HI:   state <= PF_LO;
                PF_LO: begin
                    state <= PF_FIN;
                    hi_q  <= mem_rdata;
                end
                default: state <= PF_IDLE;
            endcase
        end
    end

    assign mem_rd   = (state == PF_HI) || (state == PF_LO);
    assign mem_addr = (state == PF_LO) ? ptr_q + AW'(1) : ptr_q;
    assign busy     = (state != PF_IDLE);
    assign fin      = (state == PF_FIN);
    assign ptr_word = {hi_q, mem_rdata};

    // Second byte address follows the first by one, wrapping
    p_second_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PF_LO) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // A launch yields exactly two reads and then the finishing cycle
    p_fetch_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PF_IDLE && launch) |=> mem_rd ##1 mem_rd ##1 (fin && !mem_rd));

endmodule

// File: rtl/idx_ea_gen.sv
// Indexed effective address generator (top). Accepts a postbyte with its
// extension bytes on a start pulse, returns the final address with a done
// pulse, a write-back strobe for auto-step forms, and runs a pointer fetch
// for indirect forms. Assumes inputs are stable in the start cycle only.
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] postbyte,
    input  logic [BW-1:0] ext_hi,
    input  logic [BW-1:0] ext_lo,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_pc,
    input  logic [BW-1:0] acc_a,
    input  logic [BW-1:0] acc_b,
    input  logic [BW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [1:0]    wb_sel,
    output logic [AW-1:0] wb_val
);

    ea_kind_t      kind;
    logic [1:0]    rsel;
    logic          pre_step;
    logic [AW-1:0] offset;
    logic [AW-1:0] step;
    logic [AW-1:0] sum;
    logic [AW-1:0] stepped;
    logic          busy;
    logic          fin;
    logic [AW-1:0] ptr_word;
    logic          accept;
    logic          launch;

    idx_pb_decode #(.AW(AW), .BW(BW)) u_dec (
        .postbyte (postbyte),
        .ext_hi   (ext_hi),
        .ext_lo   (ext_lo),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .kind     (kind),
        .rsel     (rsel),
        .pre_step (pre_step),
        .offset   (offset),
        .step     (step)
    );

    idx_addr_calc #(.AW(AW)) u_calc (
        .kind     (kind),
        .rsel     (rsel),
        .pre_step (pre_step),
        .offset   (offset),
        .step     (step),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_sp   (reg_sp),
        .reg_pc   (reg_pc),
        .sum      (sum),
        .stepped  (stepped)
    );

    assign accept = start && !busy;
    assign launch = accept && (kind == EA_INDIRECT);

    idx_ptr_fetch #(.AW(AW), .BW(BW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .ptr       (sum),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .fin       (fin),
        .ptr_word  (ptr_word)
    );

    // Result registers: direct forms finish next cycle, indirect on fin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            ea     <= '0;
            wb_en  <= 1'b0;
            wb_sel <= 2'b00;
            wb_val <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            if (fin) begin
                done <= 1'b1;
                ea   <= ptr_word;
            end else if (accept && kind != EA_INDIRECT) begin
                done   <= 1'b1;
                ea     <= sum;
                wb_en  <= (kind == EA_STEP);
                wb_sel <= rsel;
                wb_val <= stepped;
            end
        end
    end

    // Write-back strobe only ever accompanies a finished address
    p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // Program counter is never a write-back target
    p_no_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_sel != 2'b11));

    // done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A start during a pointer fetch produces no result next cycle
    p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> !done);

endmodule

// File: tb/sim_idx_ea_gen.sv
module sim_idx_ea_gen;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [7:0]  ext_hi = '0;
    logic [7:0]  ext_lo = '0;
    logic [15:0] reg_x = 16'h1000;
    logic [15:0] reg_y = 16'h2000;
    logic [15:0] reg_sp = 16'h3FF0;
    logic [15:0] reg_pc = 16'hC000;
    logic [7:0]  acc_a = 8'h85;
    logic [7:0]  acc_b = 8'h7F;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        done;
    logic [15:0] ea;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .ext_hi(ext_hi), .ext_lo(ext_lo), .reg_x(reg_x), .reg_y(reg_y),
        .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
    );

    // Byte memory model: content is a function of the address
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // One-cycle read latency memory
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for done; report latency and outputs
    task automatic issue(input logic [7:0] pb, input logic [7:0] e0, input logic [7:0] e1,
                         output int lat);
        @(negedge clk);
        postbyte = pb; ext_hi = e0; ext_lo = e1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic direct(input string tag, input logic [7:0] pb, input logic [7:0] e0,
                          input logic [7:0] e1, input logic [15:0] exp_ea);
        int lat;
        issue(pb, e0, e1, lat);
        check({tag, " latency"}, lat, 1);
        check({tag, " ea"}, ea, exp_ea);
        check({tag, " no wb"}, wb_en, 0);
    endtask

    task automatic stepping(input string tag, input logic [7:0] pb, input logic [15:0] exp_ea,
                            input logic [1:0] exp_sel, input logic [15:0] exp_val);
        int lat;
        issue(pb, 8'h00, 8'h00, lat);
        check({tag, " latency"}, lat, 1);
        check({tag, " ea"}, ea, exp_ea);
        check({tag, " wb_en"}, wb_en, 1);
        check({tag, " wb_sel"}, wb_sel, exp_sel);
        check({tag, " wb_val"}, wb_val, exp_val);
    endtask

    task automatic indirect(input string tag, input logic [7:0] pb, input logic [7:0] e0,
                            input logic [7:0] e1, input logic [15:0] ptr);
        int lat;
        issue(pb, e0, e1, lat);
        check({tag, " latency"}, lat, 4);
        check({tag, " ea"}, ea, {mem_byte(ptr), mem_byte(ptr + 16'd1)});
        check({tag, " no wb"}, wb_en, 0);
    endtask

    task automatic t_reset();
        check("R10 reset done", done, 0);
        check("R10 reset wb_en", wb_en, 0);
        check("R8 reset mem_rd", mem_rd, 0);
    endtask

    task automatic t_short();
        direct("R2 X+15", 8'h0F, 8'h00, 8'h00, 16'h100F);
        direct("R2 R1 Y-16", 8'h50, 8'h00, 8'h00, 16'h1FF0);
        direct("R2 R1 PC-1", 8'hDF, 8'h00, 8'h00, 16'hBFFF);
    endtask

    task automatic t_const();
        direct("R3 X-256", 8'hE1, 8'h00, 8'h00, 16'h0F00);
        direct("R3 R1 SP+255", 8'hF0, 8'hFF, 8'h00, 16'h40EF);
        direct("R4 R9 Y+F000 wrap", 8'hEA, 8'hF0, 8'h00, 16'h1000);
    endtask

    task automatic t_step();
        stepping("R5 pre +1 X", 8'h20, 16'h1001, 2'd0, 16'h1001);
        stepping("R5 post -8 SP", 8'hB8, 16'h3FF0, 2'd2, 16'h3FE8);
        stepping("R5 pre +8 Y", 8'h67, 16'h2008, 2'd1, 16'h2008);
        stepping("R5 post -1 Y", 8'h7F, 16'h2000, 2'd1, 16'h1FFF);
    endtask

    task automatic t_acc();
        direct("R7 X+A", 8'hE4, 8'h00, 8'h00, 16'h1085);
        direct("R7 X+B", 8'hE5, 8'h00, 8'h00, 16'h107F);
        direct("R7 X+D", 8'hE6, 8'h00, 8'h00, 16'h957F);
        direct("R7 R6 PC+B", 8'hFD, 8'h00, 8'h00, 16'hC07F);
    endtask

    task automatic t_indirect();
        indirect("R8 const X", 8'hE3, 8'h00, 8'h10, 16'h1010);
        indirect("R8 D Y", 8'hEF, 8'h00, 8'h00, 16'hA57F);
        indirect("R9 ptr wrap", 8'hFB, 8'h3F, 8'hFF, 16'hFFFF);
    endtask

    // Start during a fetch must be dropped: one done, pointer result, no wb
    task automatic t_busy();
        int lat;
        int dones;
        int wbs;
        @(negedge clk);
        postbyte = 8'hE3; ext_hi = 8'h00; ext_lo = 8'h10; start = 1'b1;
        @(negedge clk);
        postbyte = 8'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0; wbs = 0; lat = 2;
        for (int i = 0; i < 6; i++) begin
            if (done) begin
                dones++;
                check("R10 busy latency", lat, 4);
                check("R10 busy ea", ea, {mem_byte(16'h1010), mem_byte(16'h1011)});
            end
            if (wb_en) wbs++;
            @(negedge clk);
            lat++;
        end
        check("R10 busy one done", dones, 1);
        check("R10 busy no wb", wbs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_const();
        t_step();
        t_acc();
        t_indirect();
        t_busy();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule